// File: doc/BRIEF.md
# Keyed Configuration Item Port

A read-only store of configuration items, each named by a 16-bit key. It is reached through a two-register access model. A write to the selector register picks an item and sets its read offset back to zero. Each access to the data register then returns the next byte of that item, in increasing address order. Reads past the end of an item, or reads of a key that has no item, return zero and leave the offset where it stands.

The item table is computed in logic and holds no writable storage. Key 0x0000 is a four-byte signature. Key 0x0001 is a 32-bit little-endian feature bitmap. A parameterised run of generated items sits at keys starting from a base key.

A second requester, a DMA engine, shares the same selector and offset state. It can select an item, fetch a byte, or skip a number of bytes. Only one operation takes effect per cycle, by fixed priority.

Top module: `cfg_item_port`

## Requirements
- R1: After reset the current key is 0x0000, the offset is 0, and both read-valid outputs and both read-data outputs are 0.
- R2: A host selector write sets the current key to the written value and the offset to 0, from the next cycle on.
- R3: A granted host read returns the byte at the current offset on `host_rdata_o`, with `host_rvalid_o` high, for exactly the one cycle after the request. The offset then advances by one.
- R4: Key 0x0000 has length 4 and holds the bytes 0x51, 0x45, 0x4D, 0x55 at offsets 0 to 3.
- R5: Key 0x0001 has length 4 and holds a little-endian 32-bit word. Bit 0 is always 1, bit 1 equals parameter `DMA_PRESENT` (default 1), and all other bits are 0.
- R6: A read at an offset equal to or beyond the item length returns 0x00 and leaves the offset unchanged. A key with no item has length 0.
- R7: A DMA select has the same effect on key and offset as a host selector write.
- R8: A granted DMA read returns the current byte on `dma_rdata_o`, with `dma_rvalid_o` high, one cycle later. It advances the shared offset by one.
- R9: A granted DMA skip advances the offset by `dma_skip_len_i`, clamped at the item length. It produces no read-valid.
- R10: At most one operation is granted per cycle, in the order host select, DMA select, host read, DMA read, DMA skip. Every other request in that cycle is dropped, with no effect on state or outputs.
- R11: Keys `EXTRA_BASE` to `EXTRA_BASE+EXTRA_COUNT-1` (defaults 0x0020, 2 items) each have length `EXTRA_LEN` (default 6). Item index i, counted from `EXTRA_BASE`, holds byte ((16*i + offset) mod 256) XOR 0x5A at each offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_sel_we_i | input | 1 | Host selector write strobe |
| host_sel_key_i | input | 16 | Key written to the selector |
| host_rd_i | input | 1 | Host data register read request |
| host_rdata_o | output | 8 | Byte returned to the host |
| host_rvalid_o | output | 1 | Host byte valid |
| dma_sel_i | input | 1 | DMA select request |
| dma_sel_key_i | input | 16 | Key chosen by the DMA engine |
| dma_rd_i | input | 1 | DMA byte fetch request |
| dma_rdata_o | output | 8 | Byte returned to the DMA engine |
| dma_rvalid_o | output | 1 | DMA byte valid |
| dma_skip_i | input | 1 | DMA skip request |
| dma_skip_len_i | input | 16 | Number of bytes to skip |
| cur_key_o | output | 16 | Currently selected key |
| cur_offset_o | output | 16 | Current read offset |
| item_len_o | output | 16 | Length of the selected item |

## Verification
The bench reads each item to its end and then beyond it. A design with off-by-one saturation would return a stale byte or let the offset run past the length. It checks that re-selecting the same key rewinds the offset, which a design that only reloads on a key change would miss. It skips past the end, where an unclamped adder would leave the offset larger than the length. It raises requests in colliding pairs: a wrong priority order, or a design that grants two operations at once, shows up as a double offset step or as a spurious valid on the losing side.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
    localparam int KEY_W  = 16;
    localparam int OFS_W  = 16;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic host_sel;
        logic dma_sel;
        logic host_rd;
        logic dma_rd;
        logic dma_skip;
    } grant_t;
endpackage

// File: rtl/cfg_item_rom.sv
module cfg_item_rom
    import cfg_port_pkg::*;
#(
    parameter bit             DMA_PRESENT = 1'b1,
    parameter logic [KEY_W-1:0] EXTRA_BASE = 16'h0020,
    parameter int             EXTRA_COUNT = 2,
    parameter int             EXTRA_LEN   = 6
) (
    input  logic [KEY_W-1:0]  key_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [OFS_W-1:0]  len_o,
    output logic [BYTE_W-1:0] byte_o
);
    localparam logic [31:0] SIG_WORD  = 32'h554D_4551;
    localparam logic [31:0] FEAT_WORD = {30'd0, DMA_PRESENT, 1'b1};
    localparam logic [OFS_W-1:0] FIXED_LEN = OFS_W'(4);
    localparam logic [OFS_W-1:0] XLEN      = OFS_W'(EXTRA_LEN);
    localparam logic [KEY_W:0]   XEND      = {1'b0, EXTRA_BASE} + (KEY_W+1)'(EXTRA_COUNT);

    logic [KEY_W-1:0]  xidx;
    logic [BYTE_W-1:0] raw;

    always_comb begin
        xidx   = key_i - EXTRA_BASE;
        len_o  = '0;
        raw    = '0;
        if (key_i == '0) begin
            len_o = FIXED_LEN;
            raw   = SIG_WORD[8*ofs_i[1:0] +: 8];
        end else if (key_i == KEY_W'(1)) begin
            len_o = FIXED_LEN;
            raw   = FEAT_WORD[8*ofs_i[1:0] +: 8];
        end else if (key_i >= EXTRA_BASE && {1'b0, key_i} < XEND) begin
            len_o = XLEN;
            raw   = ((BYTE_W'(xidx) << 4) + BYTE_W'(ofs_i)) ^ 8'h5A;
        end
        byte_o = (ofs_i < len_o) ? raw : '0;
    end
endmodule

// File: rtl/cfg_port_arb.sv
module cfg_port_arb
    import cfg_port_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   host_sel_i,
    input  logic   dma_sel_i,
    input  logic   host_rd_i,
    input  logic   dma_rd_i,
    input  logic   dma_skip_i,
    output grant_t gnt_o
);
    always_comb begin
        gnt_o          = '0;
        if (host_sel_i)      gnt_o.host_sel = 1'b1;
        else if (dma_sel_i)  gnt_o.dma_sel  = 1'b1;
        else if (host_rd_i)  gnt_o.host_rd  = 1'b1;
        else if (dma_rd_i)   gnt_o.dma_rd   = 1'b1;
        else if (dma_skip_i) gnt_o.dma_skip = 1'b1;
    end

    // R10: never more than one operation per cycle
    assert_single_grant_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));
    // R10: any request yields some grant
    assert_grant_when_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_sel_i | dma_sel_i | host_rd_i | dma_rd_i | dma_skip_i) |-> (gnt_o != '0));
endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
    import cfg_port_pkg::*;
#(
    parameter bit               DMA_PRESENT = 1'b1,
    parameter logic [KEY_W-1:0] EXTRA_BASE  = 16'h0020,
    parameter int               EXTRA_COUNT = 2,
    parameter int               EXTRA_LEN   = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              host_sel_we_i,
    input  logic [KEY_W-1:0]  host_sel_key_i,
    input  logic              host_rd_i,
    output logic [BYTE_W-1:0] host_rdata_o,
    output logic              host_rvalid_o,
    input  logic              dma_sel_i,
    input  logic [KEY_W-1:0]  dma_sel_key_i,
    input  logic              dma_rd_i,
    output logic [BYTE_W-1:0] dma_rdata_o,
    output logic              dma_rvalid_o,
    input  logic              dma_skip_i,
    input  logic [OFS_W-1:0]  dma_skip_len_i,
    output logic [KEY_W-1:0]  cur_key_o,
    output logic [OFS_W-1:0]  cur_offset_o,
    output logic [OFS_W-1:0]  item_len_o
);
    typedef struct packed {
        logic [KEY_W-1:0]  key;
        logic [OFS_W-1:0]  ofs;
        logic [BYTE_W-1:0] host_rdata;
        logic              host_rvalid;
        logic [BYTE_W-1:0] dma_rdata;
        logic              dma_rvalid;
    } state_t;

    state_t st_d, st_q;
    grant_t gnt;
    logic [OFS_W-1:0]  len;
    logic [BYTE_W-1:0] cur_byte;
    logic [OFS_W:0]    skip_sum;

    cfg_port_arb u_arb (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .host_sel_i (host_sel_we_i),
        .dma_sel_i  (dma_sel_i),
        .host_rd_i  (host_rd_i),
        .dma_rd_i   (dma_rd_i),
        .dma_skip_i (dma_skip_i),
        .gnt_o      (gnt)
    );

    cfg_item_rom #(
        .DMA_PRESENT (DMA_PRESENT),
        .EXTRA_BASE  (EXTRA_BASE),
        .EXTRA_COUNT (EXTRA_COUNT),
        .EXTRA_LEN   (EXTRA_LEN)
    ) u_rom (
        .key_i  (st_q.key),
        .ofs_i  (st_q.ofs),
        .len_o  (len),
        .byte_o (cur_byte)
    );

    always_comb begin
        st_d             = st_q;
        st_d.host_rvalid = 1'b0;
        st_d.dma_rvalid  = 1'b0;
        skip_sum         = {1'b0, st_q.ofs} + {1'b0, dma_skip_len_i};
        if (gnt.host_sel) begin
            st_d.key = host_sel_key_i;
            st_d.ofs = '0;
        end else if (gnt.dma_sel) begin
            st_d.key = dma_sel_key_i;
            st_d.ofs = '0;
        end else if (gnt.host_rd) begin
            st_d.host_rdata  = cur_byte;
            st_d.host_rvalid = 1'b1;
            if (st_q.ofs < len) st_d.ofs = st_q.ofs + 1'b1;
        end else if (gnt.dma_rd) begin
            st_d.dma_rdata  = cur_byte;
            st_d.dma_rvalid = 1'b1;
            if (st_q.ofs < len) st_d.ofs = st_q.ofs + 1'b1;
        end else if (gnt.dma_skip) begin
            if (skip_sum > {1'b0, len}) st_d.ofs = len;
            else                        st_d.ofs = skip_sum[OFS_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign host_rdata_o  = st_q.host_rdata;
    assign host_rvalid_o = st_q.host_rvalid;
    assign dma_rdata_o   = st_q.dma_rdata;
    assign dma_rvalid_o  = st_q.dma_rvalid;
    assign cur_key_o     = st_q.key;
    assign cur_offset_o  = st_q.ofs;
    assign item_len_o    = len;

    // R6 / R9: offset never passes the item length
    assert_ofs_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ofs <= len) || $past(gnt.host_sel || gnt.dma_sel) || ($past(st_q.ofs) > $past(len)));
    // R2: host selector write lands key and zero offset
    assert_sel_loads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnt.host_sel |=> (cur_key_o == $past(host_sel_key_i) && cur_offset_o == '0));
    // R7: DMA select matches the selector write
    assert_dma_sel_loads_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gnt.dma_sel |=> (cur_key_o == $past(dma_sel_key_i) && cur_offset_o == '0));
    // R3: host valid only after a granted host read
    assert_host_valid_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        host_rvalid_o |-> $past(gnt.host_rd));
    // R8: DMA valid only after a granted DMA read
    assert_dma_valid_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dma_rvalid_o |-> $past(gnt.dma_rd));
    // R6: reading at or past the end yields zero and holds the offset
    assert_past_end_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt.host_rd && st_q.ofs >= len) |=> (host_rdata_o == '0 && cur_offset_o == $past(st_q.ofs)));
    // R3: in-range read advances offset by one
    assert_read_advance_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((gnt.host_rd || gnt.dma_rd) && st_q.ofs < len) |=> (cur_offset_o == $past(st_q.ofs) + 1'b1));
endmodule

// File: tb/cfg_item_port_tb.sv
module cfg_item_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel_we = 1'b0;
    logic [15:0] host_sel_key = '0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_rdata;
    logic        host_rvalid;
    logic        dma_sel = 1'b0;
    logic [15:0] dma_sel_key = '0;
    logic        dma_rd = 1'b0;
    logic [7:0]  dma_rdata;
    logic        dma_rvalid;
    logic        dma_skip = 1'b0;
    logic [15:0] dma_skip_len = '0;
    logic [15:0] cur_key, cur_ofs, item_len;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    cfg_item_port u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .host_sel_we_i(host_sel_we), .host_sel_key_i(host_sel_key),
        .host_rd_i(host_rd), .host_rdata_o(host_rdata), .host_rvalid_o(host_rvalid),
        .dma_sel_i(dma_sel), .dma_sel_key_i(dma_sel_key),
        .dma_rd_i(dma_rd), .dma_rdata_o(dma_rdata), .dma_rvalid_o(dma_rvalid),
        .dma_skip_i(dma_skip), .dma_skip_len_i(dma_skip_len),
        .cur_key_o(cur_key), .cur_offset_o(cur_ofs), .item_len_o(item_len)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic host_select(input logic [15:0] k);
        @(negedge clk); host_sel_we = 1'b1; host_sel_key = k;
        @(negedge clk); host_sel_we = 1'b0;
    endtask

    task automatic host_read(output logic [7:0] b, output logic v);
        @(negedge clk); host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0; b = host_rdata; v = host_rvalid;
    endtask

    task automatic read_item(input string req, input logic [15:0] k, input int n, input logic [7:0] exp [8]);
        logic [7:0] b; logic v;
        host_select(k);
        chk(req, "item length", 32'(item_len), 32'(n));
        for (int i = 0; i < n; i++) begin
            host_read(b, v);
            chk(req, "byte", {23'd0, v, b}, {23'd0, 1'b1, exp[i]});
        end
    endtask

    task automatic t_reset();
        chk("R1", "key", 32'(cur_key), 0);
        chk("R1", "offset", 32'(cur_ofs), 0);
        chk("R1", "valids/data", {host_rvalid, dma_rvalid, host_rdata, dma_rdata}, 0);
    endtask

    task automatic t_signature();
        logic [7:0] e [8] = '{8'h51, 8'h45, 8'h4D, 8'h55, 0, 0, 0, 0};
        read_item("R4", 16'h0000, 4, e);
    endtask

    task automatic t_feature();
        logic [7:0] e [8] = '{8'h03, 0, 0, 0, 0, 0, 0, 0};
        read_item("R5", 16'h0001, 4, e);
    endtask

    task automatic t_extra();
        logic [7:0] e [8];
        for (int k = 0; k < 2; k++) begin
            for (int o = 0; o < 8; o++) e[o] = 8'((k * 16 + o) & 8'hFF) ^ 8'h5A;
            read_item("R11", 16'h0020 + 16'(k), 6, e);
        end
    endtask

    task automatic t_past_end_and_rewind();
        logic [7:0] b; logic v;
        host_select(16'h0000);
        for (int i = 0; i < 4; i++) host_read(b, v);
        host_read(b, v);
        chk("R6", "past-end byte", {23'd0, v, b}, {23'd0, 1'b1, 8'h00});
        chk("R6", "offset saturates", 32'(cur_ofs), 4);
        host_select(16'h0000);
        chk("R2", "reselect rewinds offset", 32'(cur_ofs), 0);
        host_read(b, v);
        chk("R3", "first byte after rewind", 32'(b), 32'h51);
        chk("R3", "offset advanced", 32'(cur_ofs), 1);
        host_select(16'h1234);
        chk("R2", "key loaded", 32'(cur_key), 32'h1234);
        chk("R6", "missing key length", 32'(item_len), 0);
        host_read(b, v);
        chk("R6", "missing key byte", {23'd0, v, b}, {23'd0, 1'b1, 8'h00});
        chk("R6", "missing key offset", 32'(cur_ofs), 0);
    endtask

    task automatic t_dma();
        @(negedge clk); dma_sel = 1'b1; dma_sel_key = 16'h0021;
        @(negedge clk); dma_sel = 1'b0;
        chk("R7", "dma select key", 32'(cur_key), 32'h21);
        chk("R7", "dma select offset", 32'(cur_ofs), 0);
        @(negedge clk); dma_rd = 1'b1;
        @(negedge clk); dma_rd = 1'b0;
        chk("R8", "dma byte", {23'd0, dma_rvalid, dma_rdata}, {23'd0, 1'b1, 8'h10 ^ 8'h5A});
        chk("R8", "dma offset", 32'(cur_ofs), 1);
        chk("R8", "host valid quiet", 32'(host_rvalid), 0);
        @(negedge clk); dma_skip = 1'b1; dma_skip_len = 16'd3;
        @(negedge clk); dma_skip = 1'b0;
        chk("R9", "skip advance", 32'(cur_ofs), 4);
        chk("R9", "skip no valid", {host_rvalid, dma_rvalid}, 0);
        @(negedge clk); dma_skip = 1'b1; dma_skip_len = 16'hFFFF;
        @(negedge clk); dma_skip = 1'b0;
        chk("R9", "skip clamps", 32'(cur_ofs), 6);
    endtask

    task automatic t_priority();
        host_select(16'h0000);
        @(negedge clk); host_rd = 1'b1; dma_rd = 1'b1; dma_skip = 1'b1; dma_skip_len = 16'd2;
        @(negedge clk); host_rd = 1'b0; dma_rd = 1'b0; dma_skip = 1'b0;
        chk("R10", "host read wins", {22'd0, host_rvalid, dma_rvalid, host_rdata}, {22'd0, 1'b1, 1'b0, 8'h51});
        chk("R10", "single advance", 32'(cur_ofs), 1);
        @(negedge clk); dma_rd = 1'b1; dma_skip = 1'b1;
        @(negedge clk); dma_rd = 1'b0; dma_skip = 1'b0;
        chk("R10", "dma read beats skip", {23'd0, dma_rvalid, dma_rdata}, {23'd0, 1'b1, 8'h45});
        chk("R10", "skip dropped", 32'(cur_ofs), 2);
        @(negedge clk); host_sel_we = 1'b1; host_sel_key = 16'h0001; dma_sel = 1'b1; dma_sel_key = 16'h0020;
        @(negedge clk); host_sel_we = 1'b0; dma_sel = 1'b0;
        chk("R10", "host select wins", 32'(cur_key), 1);
        @(negedge clk); dma_sel = 1'b1; dma_sel_key = 16'h0020; host_rd = 1'b1;
        @(negedge clk); dma_sel = 1'b0; host_rd = 1'b0;
        chk("R10", "dma select beats host read", {15'd0, host_rvalid, cur_key}, {15'd0, 1'b0, 16'h0020});
        chk("R10", "offset reset", 32'(cur_ofs), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_signature();
        t_feature();
        t_extra();
        t_past_end_and_rewind();
        t_dma();
        t_priority();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule